// File: doc/BRIEF.md
# UART Interrupt Priority and Identification

This block sits beside the register file of a 16550-style serial port. It takes the pending interrupt conditions of the port as level flags and compares each against its enable bit. It then reports the single most urgent enabled condition as a four-bit code in the low nibble of the identification read value. The same code drives the interrupt request line, which is gated by the OUT2 bit of the modem control register.

Most source conditions are generated outside this block. The transmitter-empty condition is the exception: it is kept as a pending flag inside the block, because two register accesses change it.
- A read of the identification register clears it, but only when that read reports it.
- A write of the enable register that sets the transmitter-empty enable, while the holding register is empty, raises it again.

The identification value and the request line are decoded combinationally from registered state. A change in any source flag is therefore visible at the next read with no extra delay.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held and after it is released, with no inputs active, the identification value is 0x01, the enable readback is 0x00, the request line is low and the transmitter-empty flag is clear.
- R2: When several enabled sources are pending, the one reported is chosen in this order, most urgent first: line status, character timeout, received data, transmitter empty, modem status.
- R3: Bits 3:0 of the identification value are:
  - 0x6 for line status
  - 0xC for timeout
  - 0x4 for received data
  - 0x2 for transmitter empty
  - 0x0 for modem status
  - 0x1 when no enabled source is pending (bit 0 is 1 only in this case).
- R4: Enable bit 0 gates both received data and timeout, bit 1 gates transmitter empty, bit 2 gates line status and bit 3 gates modem status. A source whose enable bit is 0 is never reported.
- R5: An enable write stores only bits 3:0 of the write data. The readback has bits 7:4 equal to zero.
- R6: A read strobe while the identification value shows 0x2 in bits 3:0 clears the transmitter-empty flag at that clock edge.
- R7: A read strobe while any other code is shown leaves the transmitter-empty flag unchanged.
- R8: Bits 7:6 of the identification value are 11 when the FIFO-enable input is 1 and 00 otherwise. Bits 5:4 are always 0.
- R9: An enable write with data bit 1 set while the holding-register-empty input is 1 sets the transmitter-empty flag. The same write with that input at 0 does not set it.
- R10: The request line is high exactly when bit 0 of the identification value is 0 and the OUT2 input is 1. Clearing OUT2 drops the request in the same cycle, with no clock edge needed.
- R11: A transmitter-empty set pulse sets the flag and a clear pulse clears it. When any set and any clear occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lsr | input | 1 | Line status condition pending (level) |
| src_timeout | input | 1 | Character timeout condition pending (level) |
| src_rxdata | input | 1 | Received data condition pending (level) |
| src_msr | input | 1 | Modem status condition pending (level) |
| thr_empty | input | 1 | Transmit holding register is empty |
| thre_set | input | 1 | Pulse: transmitter has gone empty |
| thre_clr | input | 1 | Pulse: holding register was written |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| iir_rd | input | 1 | Identification register read strobe |
| fifo_en | input | 1 | FIFOs are enabled |
| out2 | input | 1 | OUT2 bit of the modem control register |
| ier_rdata | output | 8 | Enable register readback |
| iir_rdata | output | 8 | Identification register read value |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the properties that hold in any state:
- line status always wins when enabled;
- the idle code carries no source bits;
- the reserved bits stay zero;
- the request never rises without OUT2;
- the transmitter-empty flag responds correctly to reads, re-arm writes and set pulses.

The full ordering among the five sources under mixed enable masks can only be shown by the bench's scenarios. The same holds for the exact code values and the FIFO marker bits. Two further cases also need the bench: a read that reports a higher source must leave transmitter empty pending, and a re-arm write with the holding register full must have no effect.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int DW    = 8,
  parameter int IER_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_lsr,
  input  logic          src_timeout,
  input  logic          src_rxdata,
  input  logic          src_msr,
  input  logic          thr_empty,
  input  logic          thre_set,
  input  logic          thre_clr,
  input  logic          ier_wr,
  input  logic [DW-1:0] ier_wdata,
  input  logic          iir_rd,
  input  logic          fifo_en,
  input  logic          out2,
  output logic [DW-1:0] ier_rdata,
  output logic [DW-1:0] iir_rdata,
  output logic          irq
);
  localparam logic [3:0] ID_NONE = 4'h1;
  localparam logic [3:0] ID_LS   = 4'h6;
  localparam logic [3:0] ID_TO   = 4'hC;
  localparam logic [3:0] ID_RX   = 4'h4;
  localparam logic [3:0] ID_TX   = 4'h2;
  localparam logic [3:0] ID_MS   = 4'h0;

  logic [IER_W-1:0] ier_q;
  logic             thre_pend;
  logic [3:0]       id_code;

  wire en_ls = src_lsr     & ier_q[2];
  wire en_to = src_timeout & ier_q[0];
  wire en_rx = src_rxdata  & ier_q[0];
  wire en_tx = thre_pend   & ier_q[1];
  wire en_ms = src_msr     & ier_q[3];

  always_comb begin
    if (en_ls)      id_code = ID_LS;
    else if (en_to) id_code = ID_TO;
    else if (en_rx) id_code = ID_RX;
    else if (en_tx) id_code = ID_TX;
    else if (en_ms) id_code = ID_MS;
    else            id_code = ID_NONE;
  end

  wire rearm  = ier_wr & ier_wdata[1] & thr_empty;
  wire rd_clr = iir_rd & (id_code == ID_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q     <= '0;
      thre_pend <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= ier_wdata[IER_W-1:0];
      if (thre_set | rearm)       thre_pend <= 1'b1;
      else if (thre_clr | rd_clr) thre_pend <= 1'b0;
    end
  end

  assign ier_rdata = {{(DW-IER_W){1'b0}}, ier_q};
  assign iir_rdata = {{2{fifo_en}}, {(DW-6){1'b0}}, id_code};
  assign irq       = ~id_code[0] & out2;

  p_ls_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_lsr && ier_rdata[2]) |-> iir_rdata[3:0] == 4'h6);
  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_rdata[3:0] == 4'h0) |-> iir_rdata[3:0] == 4'h1);
  p_idle_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rdata[0] |-> iir_rdata[3:1] == 3'b000);
  p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rdata[5:4] == 2'b00);
  p_ier_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier_rdata == {4'h0, $past(ier_wdata[3:0])});
  p_rd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_rdata[3:0] == 4'h2 && !thre_set &&
     !(ier_wr && ier_wdata[1] && thr_empty)) |=> !thre_pend);
  p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && ier_wdata[1] && thr_empty) |=> thre_pend);
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    thre_set |=> thre_pend);
  p_irq_out2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (out2 && !iir_rdata[0]));
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic clk = 1'b0, rst_n = 1'b0;
  logic src_lsr = 0, src_timeout = 0, src_rxdata = 0, src_msr = 0;
  logic thr_empty = 0, thre_set = 0, thre_clr = 0, ier_wr = 0, iir_rd = 0;
  logic fifo_en = 0, out2 = 0;
  logic [7:0] ier_wdata = 8'h00;
  logic [7:0] ier_rdata, iir_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  uart_irq_ident u0 (.*);

  // {lsr,to,rx,msr}[19:16] thre[15] ier[14:11] fifo[10] out2[9] iir[8:1] irq[0]
  localparam logic [19:0] VEC [12] = '{
    {4'b1111, 1'b1, 4'hF, 1'b0, 1'b1, 8'h06, 1'b1},
    {4'b0111, 1'b1, 4'hF, 1'b0, 1'b1, 8'h0C, 1'b1},
    {4'b0011, 1'b1, 4'hF, 1'b1, 1'b1, 8'hC4, 1'b1},
    {4'b0001, 1'b1, 4'hF, 1'b0, 1'b1, 8'h02, 1'b1},
    {4'b0001, 1'b0, 4'hF, 1'b0, 1'b1, 8'h00, 1'b1},
    {4'b0000, 1'b0, 4'hF, 1'b0, 1'b1, 8'h01, 1'b0},
    {4'b1111, 1'b1, 4'h0, 1'b0, 1'b1, 8'h01, 1'b0},
    {4'b1010, 1'b0, 4'hB, 1'b0, 1'b1, 8'h04, 1'b1},
    {4'b0100, 1'b1, 4'hE, 1'b0, 1'b1, 8'h02, 1'b1},
    {4'b1111, 1'b1, 4'h8, 1'b0, 1'b0, 8'h00, 1'b0},
    {4'b0001, 1'b1, 4'h2, 1'b1, 1'b0, 8'hC2, 1'b0},
    {4'b1000, 1'b0, 4'h4, 1'b1, 1'b1, 8'hC6, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr_ier(input logic [7:0] d);
    ier_wr = 1; ier_wdata = d; tick; ier_wr = 0;
  endtask

  task automatic pend(input logic s);
    thre_set = s; thre_clr = !s; tick; thre_set = 0; thre_clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3;
    chk("R1 iir in reset", iir_rdata, 8'h01);
    chk("R1 irq in reset", {7'b0, irq}, 8'h00);
    tick; tick; rst_n = 1; tick;
    chk("R1 iir after reset", iir_rdata, 8'h01);
    chk("R1 ier after reset", ier_rdata, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    wr_ier(8'h02);
    chk("R1 thre flag clear", iir_rdata, 8'h01);

    for (int i = 0; i < 12; i++) begin
      logic [19:0] v;
      v = VEC[i];
      thr_empty = 0;
      wr_ier({4'h0, v[14:11]});
      pend(v[15]);
      {src_lsr, src_timeout, src_rxdata, src_msr} = v[19:16];
      fifo_en = v[10]; out2 = v[9];
      #1;
      chk($sformatf("R2 R3 R4 R8 vec%0d iir", i), iir_rdata, v[8:1]);
      chk($sformatf("R10 vec%0d irq", i), {7'b0, irq}, {7'b0, v[0]});
    end
    {src_lsr, src_timeout, src_rxdata, src_msr} = 4'b0;
    fifo_en = 0; out2 = 1;

    wr_ier(8'hFF);
    chk("R5 upper bits dropped", ier_rdata, 8'h0F);

    wr_ier(8'h02); pend(1'b1);
    chk("R6 tx shown", iir_rdata, 8'h02);
    iir_rd = 1; tick; iir_rd = 0;
    chk("R6 cleared by read", iir_rdata, 8'h01);

    wr_ier(8'h03); pend(1'b1); src_rxdata = 1; #1;
    chk("R7 rx shown", iir_rdata, 8'h04);
    iir_rd = 1; tick; iir_rd = 0; src_rxdata = 0; #1;
    chk("R7 tx still pending", iir_rdata, 8'h02);

    out2 = 1; #1;
    chk("R10 irq with out2", {7'b0, irq}, 8'h01);
    out2 = 0; #1;
    chk("R10 irq drops at once", {7'b0, irq}, 8'h00);
    out2 = 1;

    pend(1'b0);
    thr_empty = 1; wr_ier(8'h02);
    chk("R9 rearm when empty", iir_rdata, 8'h02);
    pend(1'b0); thr_empty = 0; wr_ier(8'h02);
    chk("R9 no rearm when full", iir_rdata, 8'h01);

    thre_set = 1; thre_clr = 1; tick; thre_set = 0; thre_clr = 0;
    chk("R11 set wins", iir_rdata, 8'h02);
    thre_clr = 1; tick; thre_clr = 0;
    chk("R11 clear pulse", iir_rdata, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule